// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Assignable Prescaler

This block is the general-purpose count register of a small microcontroller. It runs in one of two modes. In internal mode it advances from the system clock at half rate. In pin mode it advances on a chosen edge of an external clock pin. The pin is synchronised to the system clock first.

An optional prescaler can sit between the tick source and the count. It divides by a power of two from 2 to 256. The mode, edge polarity, prescaler assignment and ratio arrive as static option bits from a register held elsewhere. The CPU can write the count at any time. A write restarts the prescaler and holds the count still for the next two increment events. When the count wraps from its all-ones value to zero, the block emits a one-cycle overflow pulse, which the interrupt controller latches as a flag.

Top module: `timer_counter8`

## Requirements
- R1: After reset, `count_o` is 0x00 and `ovf_o` is 0.
- R2: With `src_pin_i`=0 and `psc_on_i`=0, the count increases by one every two system clocks.
- R3: With `psc_on_i`=1, a ratio code n on `psc_rate_i` (0..7) passes one increment event per 2^(n+1) tick-source events, in both modes. In internal mode this is one increment per 2^(n+2) clocks.
- R4: With `src_pin_i`=1 and `edge_fall_i`=0, only rising edges of `tclk_i` count. The internal clock has no effect, and a static pin leaves the count unchanged.
- R5: With `src_pin_i`=1 and `edge_fall_i`=1, only falling edges of `tclk_i` count.
- R6: Each pin edge is counted at most once, however long the pin level is held.
- R7: A cycle with `wr_en_i`=1 loads `wr_data_i` into the count on the next clock. It clears the prescaler and the half-rate phase. The next two increment events after it are dropped.
- R8: When an increment takes the count from 0xFF to 0x00, `ovf_o` is 1 for exactly that one cycle, and the count reads 0x00 at the same time.
- R9: A write takes priority over an increment in the same cycle. Back-to-back writes leave the last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk_i | input | 1 | External count pin, asynchronous |
| src_pin_i | input | 1 | 0: internal half-rate tick, 1: pin edges |
| edge_fall_i | input | 1 | 0: count rising pin edges, 1: falling |
| psc_on_i | input | 1 | 1: prescaler inserted before the count |
| psc_rate_i | input | 3 | Ratio code n, division 2^(n+1) |
| wr_en_i | input | 1 | CPU write strobe for the count |
| wr_data_i | input | 8 | Value written to the count |
| count_o | output | 8 | Current count |
| ovf_o | output | 1 | One-cycle pulse on wrap to zero |

## Verification
Internal mode is swept over no prescaler and all eight ratio codes. Each setting is sampled once where only the two dropped events have passed, and once several events later. This separates a wrong ratio from a wrong drop count or a prescaler that a write does not clear.

Pin mode uses a pulse train that ends on an extra rising edge, so the rising and falling settings must give different counts. A long static stretch shows that neither the pin level nor the system clock advances the count.

A run through 0xFF checks the wrap pulse, and a burst of consecutive writes checks write priority.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_PIN      = 1'b1
    } tc8_src_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } tc8_edge_e;
endpackage

// File: rtl/tc8_edge_sync.sv
module tc8_edge_sync
    import tc8_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_i,
    output logic edge_o
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] shreg;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic [DEPTH-1:0] nxt;

    // stage 0 samples the pin, each later stage follows the one before it
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            assign nxt[gi] = pin_i;
        end else begin : g_rest
            assign nxt[gi] = st_q.shreg[gi-1];
        end
    end

    always_comb begin
        st_d.shreg = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic cur, prev;
    assign cur  = st_q.shreg[DEPTH-2];
    assign prev = st_q.shreg[DEPTH-1];

    always_comb begin
        if (tc8_edge_e'(fall_i) == EDGE_FALL) edge_o = prev & ~cur;
        else                                  edge_o = cur & ~prev;
    end
endmodule

// File: rtl/tc8_prescale.sv
module tc8_prescale #(
    parameter int PSC_W  = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic [PSC_W-1:0] limit;
    logic             hit;

    always_comb begin
        limit  = PSC_W'((1 << (int'(rate_i) + 1)) - 1);
        hit    = (st_q.cnt == limit);
        tick_o = tick_i & hit & ~clear_i;

        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = hit ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/timer_counter8.sv
module timer_counter8
    import tc8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_TICKS  = 2,
    localparam int RATE_W     = $clog2(PSC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tclk_i,
    input  logic              src_pin_i,
    input  logic              edge_fall_i,
    input  logic              psc_on_i,
    input  logic [RATE_W-1:0] psc_rate_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o
);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic              phase;
        logic [HOLD_W-1:0] hold;
        logic [CNT_W-1:0]  count;
        logic              ovf;
    } tc_state_t;

    tc_state_t st_d, st_q;

    logic pin_edge;
    logic base_tick;
    logic psc_tick;
    logic inc_tick;
    logic use_pin;

    assign use_pin = (tc8_src_e'(src_pin_i) == SRC_PIN);

    tc8_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (tclk_i),
        .fall_i (edge_fall_i),
        .edge_o (pin_edge)
    );

    tc8_prescale #(
        .PSC_W  (PSC_W),
        .RATE_W (RATE_W)
    ) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (wr_en_i | ~psc_on_i),
        .tick_i  (base_tick),
        .rate_i  (psc_rate_i),
        .tick_o  (psc_tick)
    );

    always_comb begin
        base_tick = use_pin ? pin_edge : st_q.phase;
        inc_tick  = psc_on_i ? psc_tick : base_tick;

        st_d       = st_q;
        st_d.ovf   = 1'b0;
        st_d.phase = use_pin ? 1'b0 : ~st_q.phase;

        if (wr_en_i) begin
            st_d.count = wr_data_i;
            st_d.hold  = HOLD_W'(HOLD_TICKS);
            st_d.phase = 1'b0;
        end else if (inc_tick) begin
            if (st_q.hold != '0) begin
                st_d.hold = st_q.hold - 1'b1;
            end else begin
                st_d.count = st_q.count + 1'b1;
                st_d.ovf   = &st_q.count;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign ovf_o   = st_q.ovf;
endmodule

// File: rtl/timer_counter8_chk.sv
module timer_counter8_chk #(
    parameter int CNT_W  = 8,
    parameter int RATE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_pin_i,
    input logic              wr_en_i,
    input logic [CNT_W-1:0]  wr_data_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              ovf_o
);
    // R8
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);

    // R8
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == '0));

    // R9
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (count_o == $past(wr_data_i)));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

    // R2
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !src_pin_i && count_o != $past(count_o) && !$past(wr_en_i))
        |=> $stable(count_o));

    // R7
    hold_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i) && !wr_en_i) |=> (count_o == $past(count_o)));
endmodule

bind timer_counter8 timer_counter8_chk #(
    .CNT_W  (CNT_W),
    .RATE_W (RATE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pin_i (src_pin_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .ovf_o     (ovf_o)
);

// File: tb/timer_counter8_bench.sv
`timescale 1ns/1ps
module timer_counter8_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tclk_i = 1'b0;
    logic       src_pin_i = 1'b0;
    logic       edge_fall_i = 1'b0;
    logic       psc_on_i = 1'b0;
    logic [2:0] psc_rate_i = 3'd0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'd0;
    logic [7:0] count_o;
    logic       ovf_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    timer_counter8 u_timer_counter8 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tclk_i      (tclk_i),
        .src_pin_i   (src_pin_i),
        .edge_fall_i (edge_fall_i),
        .psc_on_i    (psc_on_i),
        .psc_rate_i  (psc_rate_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .count_o     (count_o),
        .ovf_o       (ovf_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // write lands on the next rising edge; returns at the falling edge after it
    task automatic load(input logic [7:0] v);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = v;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tclk_i = 1'b1;
            repeat (3) @(negedge clk);
            tclk_i = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    function automatic int after_hold(input int events);
        return (events > 2) ? events - 2 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 count", int'(count_o), 0);
        check("R1 ovf", int'(ovf_o), 0);
        rst_n = 1'b1;

        // R2: internal mode, no prescaler, one step per two clocks
        for (int k = 2; k <= 6; k++) begin
            load(8'h40);
            repeat (2 * k + 1) @(negedge clk);
            check("R2 R7 internal direct", int'(count_o), 'h40 + after_hold(k));
        end

        // R3 R7: every ratio code, prescaler left mid-count before each write
        psc_on_i = 1'b1;
        for (int n = 0; n < 8; n++) begin
            int p;
            p = 1 << (n + 1);
            psc_rate_i = 3'(n);
            repeat (p + 3) @(negedge clk);
            load(8'h10);
            repeat (2 * p * 2 + p) @(negedge clk);
            check("R3 R7 held window", int'(count_o), 'h10);
            load(8'h20);
            repeat (2 * p * 5 + p) @(negedge clk);
            check("R3 ratio", int'(count_o), 'h20 + after_hold(5));
        end
        psc_on_i = 1'b0;

        // R4: pin mode, static pin, clock must not advance the count
        src_pin_i = 1'b1;
        edge_fall_i = 1'b0;
        load(8'h33);
        repeat (100) @(negedge clk);
        check("R4 static pin", int'(count_o), 'h33);

        // R4 R6: 5 full pulses plus one extra rise, held high
        load(8'h50);
        pin_pulses(5);
        tclk_i = 1'b1;
        repeat (40) @(negedge clk);
        check("R4 R6 rising", int'(count_o), 'h50 + after_hold(6));
        tclk_i = 1'b0;
        repeat (8) @(negedge clk);

        // R5: same train, falling edges only
        edge_fall_i = 1'b1;
        load(8'h50);
        pin_pulses(5);
        tclk_i = 1'b1;
        repeat (40) @(negedge clk);
        check("R5 falling", int'(count_o), 'h50 + after_hold(5));
        tclk_i = 1'b0;
        repeat (8) @(negedge clk);

        // R3: pin mode through divide-by-2 prescaler
        edge_fall_i = 1'b0;
        psc_on_i = 1'b1;
        psc_rate_i = 3'd0;
        load(8'h60);
        pin_pulses(10);
        repeat (8) @(negedge clk);
        check("R3 pin prescaled", int'(count_o), 'h60 + after_hold(5));
        psc_on_i = 1'b0;
        src_pin_i = 1'b0;

        // R8: wrap from FF to 00
        begin
            int pulses;
            int val_at;
            pulses = 0;
            val_at = -1;
            load(8'hFD);
            for (int c = 0; c < 14; c++) begin
                @(negedge clk);
                if (ovf_o) begin
                    pulses++;
                    val_at = int'(count_o);
                end
            end
            check("R8 pulse count", pulses, 1);
            check("R8 count at pulse", val_at, 0);
            check("R8 after wrap", int'(count_o), 2);
        end

        // R9: back-to-back writes, last wins
        @(negedge clk);
        wr_en_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wr_data_i = 8'(8'hA0 + i);
            @(negedge clk);
        end
        wr_en_i = 1'b0;
        check("R9 last write", int'(count_o), 'hA3);
        repeat (2) @(negedge clk);
        check("R9 R7 held", int'(count_o), 'hA3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule